// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Status Generator

This block watches the list registers of a virtual interrupt controller CPU interface together with a hypervisor control word and a virtual-machine control word. From them it builds the status a hypervisor needs to decide whether the guest requires maintenance. It produces a per-entry bitmap of entries that asked for an end-of-interrupt notification and have finished. It produces a second bitmap of entries that are free. It produces a status word with one bit per maintenance cause. It also drives a level-sensitive maintenance interrupt.

The list register bank arrives as one flat vector, entry `i` in bits `[64*i+63 : 64*i]`. Every output is registered, so it shows the inputs that were present at the previous rising clock edge. The number of implemented entries is set by the parameter `NUM_LR`, from 1 to 16. The bitmaps are always 16 bits wide.

List register layout: bit 63 is active, bit 62 is pending, and together they form the two-bit state. Bit 61 marks a hardware-linked entry. Bit 41 requests an end-of-interrupt notification.

Hypervisor control word bits:
- bit 0: global enable.
- bit 1: underflow enable.
- bit 2: entry-not-present enable.
- bit 3: no-pending enable.
- bit 4: group-0-enabled enable.
- bit 5: group-0-disabled enable.
- bit 6: group-1-enabled enable.
- bit 7: group-1-disabled enable.
- bits 31:27: the end-of-interrupt count.

VM control input: bit 0 is the group-0 enable and bit 1 is the group-1 enable.

Status word bits:
- bit 0: EOI.
- bit 1: underflow.
- bit 2: entry-not-present.
- bit 3: no-pending.
- bit 4: group-0 enabled.
- bit 5: group-0 disabled.
- bit 6: group-1 enabled.
- bit 7: group-1 disabled.

Top module: `vmaint_status_gen`

## Requirements
- R1: Bit i of `eoi_map` is 1 only when entry i has active (bit 63) and pending (bit 62) both 0, its hardware bit 61 is 0, and its notification-request bit 41 is 1.
- R2: Bit i of `empty_map` is 1 exactly when bits 63 and 62 of entry i are both 0. The other fields of the entry have no effect on it.
- R3: Bits of `eoi_map` and `empty_map` at positions `NUM_LR` and above always read 0.
- R4: Status bit 0 is 1 exactly when `eoi_map` has any bit set.
- R5: Status bit 1 is 1 when control bit 1 is set and the count of entries with non-zero state (`NUM_LR` minus the ones in `empty_map`) is 0 or 1.
- R6: Status bit 2 is 1 when control bit 2 is set and control bits 31:27 are non-zero.
- R7: Status bit 3 is 1 when control bit 3 is set and no implemented entry has bit 62 set.
- R8: Status bits 4, 5, 6 and 7 are 1 when their enables (control bits 4, 5, 6 and 7) are set and the VM group enable is in the matching state:
  - bit 4: group 0 is 1.
  - bit 5: group 0 is 0.
  - bit 6: group 1 is 1.
  - bit 7: group 1 is 0.
- R9: `maint_irq` is 1 only when control bit 0 is set and the status word is non-zero.
- R10: All outputs change one clock after the inputs. While `rst_n` is sampled low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lr_bank | input | NUM_LR*64 | Flat list register bank, entry i at bits 64*i+63:64*i |
| hv_ctrl | input | 32 | Hypervisor control word |
| vm_grp_en | input | 2 | VM group enables, bit 0 group 0, bit 1 group 1 |
| eoi_map | output | 16 | Finished entries that requested notification |
| empty_map | output | 16 | Entries with zero state |
| maint_status | output | 8 | Maintenance status word |
| maint_irq | output | 1 | Maintenance interrupt level |

## Verification
The assertions assume that `hv_ctrl` and `vm_grp_en` are defined, known values at each sampling edge after reset. The cause bits are checked against the enable that was present one edge earlier. The bench drives every input at the falling edge, so each vector is stable across the rising edge that captures it. Random list entries are weighted toward zero state, and each hardware or request bit is chosen independently. This makes both the underflow boundary and finished entries common.

// File: rtl/vmaint_pkg.sv
// Package: shared widths and bit positions for the maintenance status generator.
// Assumes 64-bit list register entries and a 32-bit hypervisor control word.
package vmaint_pkg;
    localparam int LR_W        = 64;
    localparam int MAX_LR      = 16;
    localparam int CNT_W       = 5;

    // list register fields
    localparam int LR_ACT_BIT  = 63;
    localparam int LR_PEND_BIT = 62;
    localparam int LR_HW_BIT   = 61;
    localparam int LR_REQ_BIT  = 41;

    // hypervisor control fields
    localparam int CTL_EN      = 0;
    localparam int CTL_UND_IE  = 1;
    localparam int CTL_NP_IE   = 2;
    localparam int CTL_NOPEND_IE = 3;
    localparam int CTL_G0ON_IE = 4;
    localparam int CTL_G0OFF_IE = 5;
    localparam int CTL_G1ON_IE = 6;
    localparam int CTL_G1OFF_IE = 7;
    localparam int CTL_CNT_LSB = 27;
    localparam int CTL_CNT_MSB = 31;

    // status word layout
    localparam int ST_W        = 8;

    typedef struct packed {
        logic g1_off;
        logic g1_on;
        logic g0_off;
        logic g0_on;
        logic no_pend;
        logic not_present;
        logic underflow;
        logic eoi;
    } maint_status_t;
endpackage

// File: rtl/vmaint_lr_decode.sv
// Module: vmaint_lr_decode
// Decodes one list register entry into empty, finished-with-notification and
// pending flags. Assumes the package field positions; other bits are ignored.
module vmaint_lr_decode
    import vmaint_pkg::*;
(
    input  logic [LR_W-1:0] lr_word,
    output logic            lr_empty,
    output logic            lr_eoi,
    output logic            lr_pending
);
    logic unused_lr_bits;

    // Purpose: classify the entry from its state, hardware and request bits.
    always_comb begin
        lr_empty   = ~(lr_word[LR_ACT_BIT] | lr_word[LR_PEND_BIT]);
        lr_eoi     = lr_empty & ~lr_word[LR_HW_BIT] & lr_word[LR_REQ_BIT];
        lr_pending = lr_word[LR_PEND_BIT];
    end

    assign unused_lr_bits = ^{lr_word[LR_HW_BIT-1:LR_REQ_BIT+1], lr_word[LR_REQ_BIT-1:0]};
endmodule

// File: rtl/vmaint_status_core.sv
// Module: vmaint_status_core
// Combines the per-entry bitmaps with the control words into the maintenance
// status word. Assumes empty_map bits at or above NUM_LR are zero.
module vmaint_status_core
    import vmaint_pkg::*;
#(
    parameter int NUM_LR = 8
)
(
    input  logic [MAX_LR-1:0] eoi_map,
    input  logic [MAX_LR-1:0] empty_map,
    input  logic              pend_any,
    input  logic [31:0]       hv_ctrl,
    input  logic [1:0]        vm_grp_en,
    output maint_status_t     status
);
    localparam logic [CNT_W-1:0] NUM_LR_C = CNT_W'(NUM_LR);

    logic [CNT_W-1:0] empty_cnt;
    logic [CNT_W-1:0] used_cnt;
    logic             unused_ctl_bits;

    // Purpose: count the free entries in the bitmap.
    always_comb begin
        empty_cnt = '0;
        for (int i = 0; i < MAX_LR; i++) begin
            empty_cnt = empty_cnt + CNT_W'(empty_map[i]);
        end
        used_cnt = NUM_LR_C - empty_cnt;
    end

    // Purpose: evaluate each maintenance cause under its own enable.
    always_comb begin
        status.eoi         = |eoi_map;
        status.underflow   = hv_ctrl[CTL_UND_IE] && (used_cnt <= CNT_W'(1));
        status.not_present = hv_ctrl[CTL_NP_IE] && (hv_ctrl[CTL_CNT_MSB:CTL_CNT_LSB] != '0);
        status.no_pend     = hv_ctrl[CTL_NOPEND_IE] && !pend_any;
        status.g0_on       = hv_ctrl[CTL_G0ON_IE]  &&  vm_grp_en[0];
        status.g0_off      = hv_ctrl[CTL_G0OFF_IE] && !vm_grp_en[0];
        status.g1_on       = hv_ctrl[CTL_G1ON_IE]  &&  vm_grp_en[1];
        status.g1_off      = hv_ctrl[CTL_G1OFF_IE] && !vm_grp_en[1];
    end

    assign unused_ctl_bits = ^{hv_ctrl[CTL_CNT_LSB-1:CTL_G1OFF_IE+1], hv_ctrl[CTL_EN]};
endmodule

// File: rtl/vmaint_status_gen.sv
// Module: vmaint_status_gen (top)
// Decodes NUM_LR list register entries, builds the maintenance status word and
// registers all outputs. Assumes 1 <= NUM_LR <= 16 and synchronous inputs.
module vmaint_status_gen
    import vmaint_pkg::*;
#(
    parameter int NUM_LR = 8
)
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LR*LR_W-1:0] lr_bank,
    input  logic [31:0]            hv_ctrl,
    input  logic [1:0]             vm_grp_en,
    output logic [MAX_LR-1:0]      eoi_map,
    output logic [MAX_LR-1:0]      empty_map,
    output logic [ST_W-1:0]        maint_status,
    output logic                   maint_irq
);
    logic [MAX_LR-1:0] eoi_nxt;
    logic [MAX_LR-1:0] empty_nxt;
    logic [MAX_LR-1:0] pend_nxt;
    maint_status_t     status_nxt;
    logic              irq_nxt;

    // one decoder per implemented entry, zeros above
    for (genvar g = 0; g < MAX_LR; g++) begin : g_lr
        if (g < NUM_LR) begin : g_impl
            vmaint_lr_decode u_dec (
                .lr_word    (lr_bank[g*LR_W +: LR_W]),
                .lr_empty   (empty_nxt[g]),
                .lr_eoi     (eoi_nxt[g]),
                .lr_pending (pend_nxt[g])
            );
        end else begin : g_absent
            assign empty_nxt[g] = 1'b0;
            assign eoi_nxt[g]   = 1'b0;
            assign pend_nxt[g]  = 1'b0;
        end
    end

    vmaint_status_core #(.NUM_LR(NUM_LR)) u_core (
        .eoi_map   (eoi_nxt),
        .empty_map (empty_nxt),
        .pend_any  (|pend_nxt),
        .hv_ctrl   (hv_ctrl),
        .vm_grp_en (vm_grp_en),
        .status    (status_nxt)
    );

    // Purpose: gate the interrupt level with the global enable.
    always_comb begin
        irq_nxt = hv_ctrl[CTL_EN] && (status_nxt != '0);
    end

    // Purpose: register all outputs, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_map      <= '0;
            empty_map    <= '0;
            maint_status <= '0;
            maint_irq    <= 1'b0;
        end else begin
            eoi_map      <= eoi_nxt;
            empty_map    <= empty_nxt;
            maint_status <= status_nxt;
            maint_irq    <= irq_nxt;
        end
    end

    // a finished entry must also be free
    assert_eoi_implies_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_map & ~empty_map) == '0);

    // no bits above the implemented entries
    assert_upper_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((eoi_map | empty_map) >> NUM_LR) == '0);

    // EOI status bit tracks the registered bitmap
    assert_eoi_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        maint_status[0] == (|eoi_map));

    // underflow needs its enable one edge earlier
    assert_underflow_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        maint_status[1] |-> $past(hv_ctrl[CTL_UND_IE]));

    // no-pending needs its enable one edge earlier
    assert_nopend_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        maint_status[3] |-> $past(hv_ctrl[CTL_NOPEND_IE]));

    // interrupt only with a cause present
    assert_irq_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        maint_irq |-> (maint_status != '0));

    // interrupt only with the global enable set one edge earlier
    assert_irq_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        maint_irq |-> $past(hv_ctrl[CTL_EN]));
endmodule

// File: tb/vmaint_status_gen_test.sv
module vmaint_status_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_LR     = 8;
    localparam int BANK_W     = NUM_LR * 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [BANK_W-1:0] lr_bank;
    logic [31:0]       hv_ctrl;
    logic [1:0]        vm_grp_en;
    logic [15:0]       eoi_map;
    logic [15:0]       empty_map;
    logic [7:0]        maint_status;
    logic              maint_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmaint_status_gen #(.NUM_LR(NUM_LR)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lr_bank      (lr_bank),
        .hv_ctrl      (hv_ctrl),
        .vm_grp_en    (vm_grp_en),
        .eoi_map      (eoi_map),
        .empty_map    (empty_map),
        .maint_status (maint_status),
        .maint_irq    (maint_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_empty(input logic [BANK_W-1:0] b);
        logic [15:0] m = '0;
        for (int i = 0; i < NUM_LR; i++) m[i] = (b[i*64+62] == 1'b0) && (b[i*64+63] == 1'b0);
        return m;
    endfunction

    function automatic logic [15:0] ref_eoi(input logic [BANK_W-1:0] b);
        logic [15:0] m = '0;
        for (int i = 0; i < NUM_LR; i++)
            m[i] = !b[i*64+63] && !b[i*64+62] && !b[i*64+61] && b[i*64+41];
        return m;
    endfunction

    function automatic logic [7:0] ref_status(input logic [BANK_W-1:0] b,
                                              input logic [31:0] h, input logic [1:0] v);
        logic [7:0] s = '0;
        int used = 0;
        bit pend = 1'b0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (b[i*64+63] || b[i*64+62]) used++;
            if (b[i*64+62]) pend = 1'b1;
        end
        s[0] = (ref_eoi(b) != 0);
        s[1] = h[1] && (used <= 1);
        s[2] = h[2] && (h[31:27] != 0);
        s[3] = h[3] && !pend;
        s[4] = h[4] && v[0];
        s[5] = h[5] && !v[0];
        s[6] = h[6] && v[1];
        s[7] = h[7] && !v[1];
        return s;
    endfunction

    // compare every output against the model for the inputs now applied
    task automatic check_all();
        logic [7:0] s = ref_status(lr_bank, hv_ctrl, vm_grp_en);
        logic [15:0] ee = ref_eoi(lr_bank);
        logic [15:0] em = ref_empty(lr_bank);
        check("R1 eoi_map", {16'h0, eoi_map}, {16'h0, ee});
        check("R2 empty_map", {16'h0, empty_map}, {16'h0, em});
        check("R3 upper bits", {16'h0, eoi_map[15:NUM_LR], empty_map[15:NUM_LR]}, 32'h0);
        check("R4 eoi status", {31'h0, maint_status[0]}, {31'h0, s[0]});
        check("R5 underflow", {31'h0, maint_status[1]}, {31'h0, s[1]});
        check("R6 not present", {31'h0, maint_status[2]}, {31'h0, s[2]});
        check("R7 no pending", {31'h0, maint_status[3]}, {31'h0, s[3]});
        check("R8 group bits", {28'h0, maint_status[7:4]}, {28'h0, s[7:4]});
        check("R9 irq", {31'h0, maint_irq}, {31'h0, hv_ctrl[0] && (s != 0)});
    endtask

    task automatic apply(input logic [BANK_W-1:0] b, input logic [31:0] h, input logic [1:0] v);
        @(negedge clk);
        lr_bank = b; hv_ctrl = h; vm_grp_en = v;
        @(negedge clk);
        check_all();
    endtask

    function automatic logic [63:0] rand_lr();
        logic [63:0] w = {$urandom, $urandom};
        if (($urandom % 4) != 0) w[63:62] = 2'b00;
        return w;
    endfunction

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        logic [BANK_W-1:0] b;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        lr_bank = '1; hv_ctrl = 32'hFFFF_FFFF; vm_grp_en = 2'b11;
        repeat (3) @(negedge clk);
        // R10: reset clears every output
        check("R10 reset maps", {eoi_map, empty_map}, 32'h0);
        check("R10 reset status", {23'h0, maint_status, maint_irq}, 32'h0);
        rst_n = 1'b1;

        // all entries free, every enable set, groups off
        apply('0, 32'h0000_00FF, 2'b00);
        check("R8 directed all-free status", {24'h0, maint_status}, 32'h0000_00AA);

        // R10: outputs hold until the next rising edge
        @(negedge clk);
        b = '0;
        for (int i = 0; i < NUM_LR; i++) b[i*64+41] = 1'b1;
        lr_bank = b; vm_grp_en = 2'b11;
        #1;
        check("R10 latency hold", {16'h0, eoi_map}, 32'h0);
        @(negedge clk);
        check_all();
        check("R1 all finished", {16'h0, eoi_map}, 32'h0000_00FF);

        // R1: hardware bit suppresses the notification
        b[3*64+61] = 1'b1;
        apply(b, 32'h0000_00FF, 2'b11);
        check("R1 hw entry", {31'h0, eoi_map[3]}, 32'h0);

        // R5: one used entry underflows, two do not
        b = '0; b[63] = 1'b1;
        apply(b, 32'h0000_0002, 2'b00);
        check("R5 one used", {31'h0, maint_status[1]}, 32'h1);
        b[64+63] = 1'b1;
        apply(b, 32'h0000_0002, 2'b00);
        check("R5 two used", {31'h0, maint_status[1]}, 32'h0);

        // R7: a pending entry clears no-pending
        b = '0; b[5*64+62] = 1'b1;
        apply(b, 32'h0000_0008, 2'b00);
        check("R7 pending present", {31'h0, maint_status[3]}, 32'h0);

        // R6: count field with and without enable
        apply('0, 32'h0800_0004, 2'b00);
        check("R6 count set", {31'h0, maint_status[2]}, 32'h1);
        apply('0, 32'h0800_0000, 2'b00);
        check("R6 disabled", {31'h0, maint_status[2]}, 32'h0);

        // R9: causes present but global enable off
        apply('0, 32'h0000_00FE, 2'b01);
        check("R9 enable off", {31'h0, maint_irq}, 32'h0);

        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < NUM_LR; i++) b[i*64 +: 64] = rand_lr();
            apply(b, $urandom, 2'($urandom));
        end

        done = 1'b1;
        summary();
    end
endmodule